// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word for one downstream port of a USB host controller root hub. The bus side is a 32-bit register with a read bus and a single-cycle write strobe. The lower half of the word gives live port state: connect, enable, suspend, over-current, reset in progress, power and low-speed device. The upper half holds sticky change flags that tell the driver which state moved since the flags were last cleared.

A write does not store the value. Each 1 in a status position is a command. A 1 at bit 1 asks for the port to be enabled. A 1 at bit 0 asks for it to be disabled. A 1 in a change-flag position clears that flag. Zeros have no effect. The port-side inputs drive the rest:
- attach and detach pulses;
- over-current, power, suspend, reset and low-speed level signals;
- a babble pulse;
- reset-complete and resume-complete pulses.

While the `busy` input shows that a bus transaction is in progress, a write is held back. It is applied on the first clock edge at which `busy` is low.

Top module: `rh_port_status`

## Requirements
- R1: After synchronous reset, with `cfg_fixed_dev` low, `rd_data` reads 0x00000000.
- R2: Bits 2 (suspend), 3 (over-current), 4 (reset in progress), 8 (power) and 9 (low-speed) show the levels of `port_suspended`, `oc_level`, `port_in_reset`, `port_powered` and `ls_device`, sampled one clock earlier. Bits 5–7, 10–15 and 21–31 always read 0.
- R3: When a write is applied with bit 1 = 1 and the port is connected, bit 1 (enable) becomes 1 on that edge. Bit 1 = 0 in a write has no effect.
- R4: A write applied with bit 0 = 1 clears enable, and this clear wins over a bit-1 request in the same write. No write ever changes bit 0 (connect).
- R5: An enable request, whether from a write or from a reset or resume completion, leaves enable at 0 when the port is not connected. A write request in that case sets bit 16 (connect change).
- R6: Any of `ev_detach`, `oc_level` high, `port_powered` low or `ev_babble` forces enable to 0 on that edge. This disable beats every enable request. If enable was 1, it also sets bit 17 (enable change).
- R7: `ev_reset_done` sets bit 20 (reset change), and `ev_resume_done` sets bit 18 (suspend change). Either pulse sets enable when the port is connected.
- R8: `ev_attach` sets connect, and `ev_detach` clears it; detach wins if both arrive together. Bit 16 is set whenever the stored connect value actually changes.
- R9: Bit 19 (over-current change) is set whenever `oc_level` differs from its value at the previous edge.
- R10: In an applied write, a 1 in any of bits 16–20 clears that change flag, and a 0 leaves it alone. If a hardware set and a clear hit the same flag on the same edge, the flag ends at 1.
- R11: A write on an edge where `busy` is 1 is held, not applied. A later write during the busy period replaces the held one. The held write is applied on the first edge with `busy` low. A new write on that same edge takes the place of the held one.
- R12: While `cfg_fixed_dev` is 1 (its value sampled at the previous edge), bit 0 reads 1 and the port counts as connected for enable requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write command word |
| rd_data | output | 32 | Register read value |
| busy | input | 1 | Bus transaction in progress |
| cfg_fixed_dev | input | 1 | Attached device is non-removable |
| ev_attach | input | 1 | Device attach pulse |
| ev_detach | input | 1 | Device detach pulse |
| ev_babble | input | 1 | Bus error pulse |
| ev_reset_done | input | 1 | Port reset completed pulse |
| ev_resume_done | input | 1 | Port resume completed pulse |
| oc_level | input | 1 | Over-current condition level |
| port_powered | input | 1 | Port power is on |
| port_suspended | input | 1 | Port is suspended |
| port_in_reset | input | 1 | Port reset is being driven |
| ls_device | input | 1 | Low-speed device attached |

## Verification
Every bit of state is visible in `rd_data` one edge after it changes. Because of this, a wrong value in the enable, connect or flag flops shows up at the next compare with nothing in between.

A write that is held and never released, or released too early, is the one fault that can stay hidden. Enable and the flags then look right until `busy` falls. The scenarios therefore write during busy periods and check the word on the first idle edge.

A flag that is set but cleared in the same cycle shows up one edge later, as a 0 where the hardware set should have won.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_FLAGS  = 5;
  localparam int FLAG_BASE  = 16;
  // status bit positions
  localparam int B_CONN  = 0;
  localparam int B_EN    = 1;
  localparam int B_SUSP  = 2;
  localparam int B_OC    = 3;
  localparam int B_RST   = 4;
  localparam int B_PWR   = 8;
  localparam int B_LS    = 9;
  // change flag indices (bit = FLAG_BASE + index)
  localparam int F_CONN  = 0;
  localparam int F_EN    = 1;
  localparam int F_SUSP  = 2;
  localparam int F_OC    = 3;
  localparam int F_RST   = 4;
endpackage

// File: rtl/rh_write_hold.sv
module rh_write_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         busy,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         apply,
  output logic [W-1:0] apply_data
);
  logic         pend_v;
  logic [W-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (busy) begin
      if (wr_en) begin
        pend_v <= 1'b1;
        pend_d <= wr_data;
      end
    end else begin
      pend_v <= 1'b0;
    end
  end

  always_comb begin
    apply      = !busy && (wr_en || pend_v);
    apply_data = wr_en ? wr_data : pend_d;
  end

  // R11: a write during a busy cycle is parked for a later edge
  assert_write_parked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> pend_v);
  // R11: nothing remains parked after an idle edge
  assert_park_drained_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !pend_v);
endmodule

// File: rtl/rh_change_flags.sv
module rh_change_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags[i] <= 1'b0;
      else if (set_v[i]) flags[i] <= 1'b1;
      else if (clr_v[i]) flags[i] <= 1'b0;
    end

    // R10: a hardware set is never lost to a same-edge clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      set_v[i] |=> flags[i]);
  end
endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             busy,
  input  logic             cfg_fixed_dev,
  input  logic             ev_attach,
  input  logic             ev_detach,
  input  logic             ev_babble,
  input  logic             ev_reset_done,
  input  logic             ev_resume_done,
  input  logic             oc_level,
  input  logic             port_powered,
  input  logic             port_suspended,
  input  logic             port_in_reset,
  input  logic             ls_device
);
  logic             apply;
  logic [REG_W-1:0] wd;
  logic             conn_q, en_q, fixed_q;
  logic             susp_q, oc_q, rstp_q, pwr_q, ls_q;
  logic             eff_conn, conn_n, req_en, req_dis, hw_kill, auto_en;
  logic [NUM_FLAGS-1:0] f_set, f_clr, flags;

  rh_write_hold #(.W(REG_W)) u_hold (
    .clk(clk), .rst(rst), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .apply(apply), .apply_data(wd)
  );

  always_comb begin
    eff_conn = conn_q || fixed_q;
    conn_n   = ev_detach ? 1'b0 : (ev_attach ? 1'b1 : conn_q);
    req_dis  = apply && wd[B_CONN];
    req_en   = apply && wd[B_EN];
    auto_en  = ev_reset_done || ev_resume_done;
    hw_kill  = ev_detach || oc_level || !port_powered || ev_babble;

    f_set         = '0;
    f_set[F_CONN] = (conn_n != conn_q) || (req_en && !eff_conn);
    f_set[F_EN]   = hw_kill && en_q;
    f_set[F_SUSP] = ev_resume_done;
    f_set[F_OC]   = oc_level != oc_q;
    f_set[F_RST]  = ev_reset_done;
    f_clr = apply ? wd[FLAG_BASE +: NUM_FLAGS] : '0;
  end

  rh_change_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_v(f_set), .clr_v(f_clr), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q  <= 1'b0;
      en_q    <= 1'b0;
      fixed_q <= 1'b0;
      susp_q  <= 1'b0;
      oc_q    <= 1'b0;
      rstp_q  <= 1'b0;
      pwr_q   <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      conn_q  <= conn_n;
      fixed_q <= cfg_fixed_dev;
      susp_q  <= port_suspended;
      oc_q    <= oc_level;
      rstp_q  <= port_in_reset;
      pwr_q   <= port_powered;
      ls_q    <= ls_device;
      if (hw_kill || req_dis)                  en_q <= 1'b0;
      else if ((req_en || auto_en) && eff_conn) en_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_CONN] = eff_conn;
    rd_data[B_EN]   = en_q;
    rd_data[B_SUSP] = susp_q;
    rd_data[B_OC]   = oc_q;
    rd_data[B_RST]  = rstp_q;
    rd_data[B_PWR]  = pwr_q;
    rd_data[B_LS]   = ls_q;
    rd_data[FLAG_BASE +: NUM_FLAGS] = flags;
  end

  // R5: enable only rises while the port counts as connected
  assert_enable_needs_conn_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(eff_conn));
  // R6: a disable condition leaves enable low after the edge
  assert_hw_kill_R6: assert property (@(posedge clk) disable iff (rst)
    hw_kill |=> !en_q);
endmodule

// File: tb/tb_rh_port_status.sv
`timescale 1ns/1ps
module tb_rh_port_status;
  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 0, busy = 0, cfg_fixed_dev = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic        ev_attach = 0, ev_detach = 0, ev_babble = 0;
  logic        ev_reset_done = 0, ev_resume_done = 0;
  logic        oc_level = 0, port_powered = 0, port_suspended = 0;
  logic        port_in_reset = 0, ls_device = 0;

  int n_chk = 0, n_bad = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  rh_port_status dut (.*);

  // behavioural reference model
  bit m_conn, m_en, m_fix, m_susp, m_oc, m_rstp, m_pwr, m_ls, m_pv;
  bit [4:0]  m_fl;
  bit [31:0] m_pd;

  function automatic bit [31:0] model_word();
    bit [31:0] w = 0;
    w[0] = m_conn | m_fix; w[1] = m_en; w[2] = m_susp; w[3] = m_oc;
    w[4] = m_rstp; w[8] = m_pwr; w[9] = m_ls; w[20:16] = m_fl;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_conn = 0; m_en = 0; m_fix = 0; m_susp = 0; m_oc = 0; m_rstp = 0;
      m_pwr = 0; m_ls = 0; m_pv = 0; m_fl = 0; m_pd = 0;
    end else begin
      bit conn_ok, app, kill, en_ask, nconn;
      bit [31:0] w;
      bit [4:0] setf;
      conn_ok = m_conn | m_fix;
      app = !busy && (wr_en || m_pv);
      w = wr_en ? wr_data : m_pd;
      if (busy) begin
        if (wr_en) begin m_pv = 1; m_pd = wr_data; end
      end else m_pv = 0;
      nconn = ev_detach ? 0 : (ev_attach ? 1 : m_conn);
      kill = ev_detach | oc_level | !port_powered | ev_babble;
      en_ask = (app && w[1]) || ev_reset_done || ev_resume_done;
      setf = 0;
      setf[0] = (nconn != m_conn) || (app && w[1] && !conn_ok);
      setf[1] = kill && m_en;
      setf[2] = ev_resume_done;
      setf[3] = oc_level != m_oc;
      setf[4] = ev_reset_done;
      if (app) m_fl = m_fl & ~w[20:16];
      m_fl = m_fl | setf;
      if (kill || (app && w[0])) m_en = 0;
      else if (en_ask && conn_ok) m_en = 1;
      m_conn = nconn; m_fix = cfg_fixed_dev; m_susp = port_suspended;
      m_oc = oc_level; m_rstp = port_in_reset; m_pwr = port_powered; m_ls = ls_device;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (rd_data !== model_word()) begin
        n_bad++;
        $display("FAIL %s: cycle compare rd_data=%h expected=%h", phase, rd_data, model_word());
      end
    end
  end

  task automatic chk(input string tag, input bit [31:0] got, input bit [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit [31:0] d);
    wr_en = 1; wr_data = d; cyc(1); wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    cyc(3); rst = 0;
    chk("R1", rd_data, 32'h0);                 // R1 reset value
    phase = "R2";
    port_powered = 1; port_suspended = 1; ls_device = 1; port_in_reset = 1;
    cyc(1);
    chk("R2", rd_data, 32'h0000_0314);         // R2 mirrored levels, reserved zero
    port_suspended = 0; port_in_reset = 0; cyc(1);
    chk("R2", rd_data, 32'h0000_0300);
    phase = "R8";
    pulse(ev_attach);
    chk("R8", rd_data & 32'h0001_0001, 32'h0001_0001);
    pulse(ev_attach);                          // no toggle: R8
    wr(32'h0001_0000);
    chk("R10", rd_data[16], 1'b0);             // R10 write-1-clear
    phase = "R3";
    wr(32'h0000_0000);
    chk("R3", rd_data[1], 1'b0);
    wr(32'h0000_0002);
    chk("R3", rd_data[1], 1'b1);               // R3 enable request
    phase = "R4";
    wr(32'h0000_0003);
    chk("R4", rd_data[1:0], 2'b01);            // R4 clear wins, connect untouched
    phase = "R5";
    ev_attach = 1; ev_detach = 1; cyc(1); ev_attach = 0; ev_detach = 0;
    chk("R8", rd_data[0], 1'b0);               // R8 detach wins
    wr(32'h0001_0000);
    wr(32'h0000_0002);
    chk("R5", rd_data & 32'h0001_0003, 32'h0001_0000); // R5
    pulse(ev_reset_done);
    chk("R5", rd_data[1], 1'b0);
    phase = "R6";
    pulse(ev_attach); wr(32'h001F_0002);
    chk("R3", rd_data & 32'h001F_0003, 32'h0000_0003);
    pulse(ev_babble);
    chk("R6", rd_data & 32'h0002_0002, 32'h0002_0000); // R6
    wr(32'h0002_0000); pulse(ev_babble);
    chk("R6", rd_data[17], 1'b0);              // R6 no flag when already off
    wr(32'h0000_0002); port_powered = 0; cyc(1); port_powered = 1;
    chk("R6", rd_data[17:16], 2'b10);
    phase = "R7";
    wr(32'h0002_0000);
    pulse(ev_reset_done);
    chk("R7", rd_data & 32'h0010_0002, 32'h0010_0002); // R7
    wr(32'h0000_0001); pulse(ev_resume_done);
    chk("R7", rd_data & 32'h0004_0002, 32'h0004_0002);
    phase = "R10";
    ev_reset_done = 1; wr(32'h0010_0000); ev_reset_done = 0;
    chk("R10", rd_data[20], 1'b1);             // R10 hardware set wins
    phase = "R9";
    oc_level = 1; cyc(1);
    chk("R9", rd_data & 32'h0008_000A, 32'h0008_0008); // R9, R6
    wr(32'h0008_0000); oc_level = 0; cyc(1);
    chk("R9", rd_data[19], 1'b1);
    phase = "R11";
    wr(32'h001F_0002);
    busy = 1; wr(32'h0000_0001); cyc(1);
    chk("R11", rd_data[1], 1'b1);              // R11 held
    wr(32'h0004_0000); cyc(1);
    busy = 0; cyc(1);
    chk("R11", rd_data[1], 1'b1);              // R11 replaced, not disabled
    busy = 1; wr(32'h0000_0001); busy = 0;
    wr(32'h0000_0000);
    chk("R11", rd_data[1], 1'b1);              // R11 new write replaces held one
    phase = "R12";
    pulse(ev_detach); wr(32'h001F_0000);
    cfg_fixed_dev = 1; cyc(1);
    chk("R12", rd_data[0], 1'b1);              // R12
    wr(32'h0000_0002);
    chk("R12", rd_data & 32'h0001_0003, 32'h0000_0003);
    cfg_fixed_dev = 0; cyc(1);
    phase = "random R3 R4 R5 R6 R7 R8 R9 R10 R11 R12";
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 3) == 0;
      wr_data = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'h001F_0003);
      busy = ($urandom % 4) == 0;
      ev_attach = ($urandom % 10) == 0;
      ev_detach = ($urandom % 20) == 0;
      ev_babble = ($urandom % 30) == 0;
      ev_reset_done = ($urandom % 15) == 0;
      ev_resume_done = ($urandom % 15) == 0;
      if ($urandom % 25 == 0) oc_level = ~oc_level;
      if ($urandom % 40 == 0) port_powered = ~port_powered;
      if ($urandom % 20 == 0) cfg_fixed_dev = ~cfg_fixed_dev;
      port_suspended = $urandom; port_in_reset = $urandom; ls_device = $urandom;
      cyc(1);
    end
    summary();
  end
endmodule